// File: doc/BRIEF.md
# Open-Row DRAM Read Sequencer

This block accepts word read requests from a client and turns them into row-strobe and column-strobe cycles on a simplified DRAM command interface. Row and column share one address bus. The row goes out first, qualified by the row strobe, and the column follows qualified by the column strobe. After a row is activated it stays open. A later request for the same row costs only a column strobe, so the client sees the column-to-data latency and nothing more. A request for another row first takes the row strobe low for a precharge period, and then the new row is opened.

A request carries a starting column and a length. A length above one makes the request a burst. One column strobe is issued per clock on consecutive columns, counting upward from the start column, and the row is closed automatically after the last word. A burst that would run past the last column of the row stops at that column. Every returned word is a full data-width slice read in parallel across the bit planes. The final word of each request comes with a completion pulse that reports how many words were delivered. Refresh, banks and electrical timing are not handled by this block.

Top module: `pgdram_seq`

## Requirements
- R1: After reset the row strobe and column strobe are low, no read data or completion is flagged, and `req_ready` is high.
- R2: A request accepted while no row is open drives the row on `dr_addr` with `dr_ras` rising. The column strobe follows T_RCD cycles later, and the first word is flagged on `rd_valid` T_RCD+T_CL cycles after the accepting edge.
- R3: A request whose row equals the open row issues only a column strobe, with `dr_ras` staying high. Its first word returns T_CL cycles after acceptance, and such single-word hits are accepted on consecutive cycles.
- R4: `dr_cas` is never high while `dr_ras` is low, and `dr_ras` stays high for as long as a row is open.
- R5: A request for a row other than the open one takes `dr_ras` low and holds `req_ready` low for T_RP cycles, then opens the new row. Its first word returns T_RP+T_RCD+T_CL cycles after acceptance.
- R6: A request with `req_len` above one issues one column strobe per clock on columns start, start+1, start+2 and so on. Its words return on consecutive cycles, and each word equals the array contents at its row and column.
- R7: A burst is clamped so that it ends at column 2^COL_W-1. On its last word `done_valid` pulses together with `rd_valid`, and `done_words` gives the number of words delivered.
- R8: After the last column strobe of a burst, the row is closed (`dr_ras` low). Any following request, even one for the same row, opens the row again with the T_RCD+T_CL latency.
- R9: A `req_len` of zero is treated as one. It delivers a single word, reports a count of 1 and leaves the row open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_row | input | ROW_W | Row of the requested word |
| req_col | input | COL_W | Starting column |
| req_len | input | COL_W+1 | Word count; 0 and 1 mean single word, above 1 means burst |
| dr_ras | output | 1 | Row strobe, high while a row is open |
| dr_cas | output | 1 | Column strobe, high for one cycle per word |
| dr_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dr_rdata | input | DATA_W | Data from the array, valid T_CL cycles after a column strobe |
| rd_valid | output | 1 | Returned word valid |
| rd_data | output | DATA_W | Returned word |
| done_valid | output | 1 | Last word of a request |
| done_words | output | COL_W+1 | Words delivered by the completed request |

## Verification
Two functions can fall into the same cycle. One is the issue of a burst's final column, which also schedules the automatic row close. The other is a new request for that same row waiting at the client port. The bench presents such a request while the burst is still running and holds it valid. It then checks that the request is not taken as an open-row hit. The request must be taken only after the close, it must cost a fresh row strobe, and its first word must come back with the closed-row latency and the right contents. Back-to-back same-row hits, where each new column strobe coincides with earlier data coming back, are judged by cycle stamps on the returned words.

// File: rtl/pgd_pkg.sv
// Shared types of the open-row DRAM read sequencer.
package pgd_pkg;
    // Control states: closed, precharging, activating, row open, bursting, closing.
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_PRE,
        PS_ACT,
        PS_OPEN,
        PS_BURST,
        PS_CLOSE
    } pgd_state_e;
endpackage

// File: rtl/pgd_delay.sv
// Down counter for precharge and row-to-column waits.
// Assumes: load takes priority; done is high when the count is zero.
module pgd_delay #(
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    // Load a new wait or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pgd_burst_gen.sv
// Column and word-count generator for one request.
// Clamps the length to the columns left in the row. Holds the next column
// and the remaining words. When load and first_issue coincide, the start
// column is being issued in that same cycle.
module pgd_burst_gen #(
    parameter int COL_W = 5,
    parameter int CNT_W = COL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             first_issue,
    input  logic             adv,
    input  logic [COL_W-1:0] start_col,
    input  logic [CNT_W-1:0] req_len,
    output logic [CNT_W-1:0] words_w,
    output logic             burst_w,
    output logic [COL_W-1:0] cur_col,
    output logic [CNT_W-1:0] rem_cnt,
    output logic [CNT_W-1:0] total,
    output logic             burst_r
);
    localparam int NCOL = 2 ** COL_W;

    logic [CNT_W-1:0] len_eff;
    logic [CNT_W-1:0] room;
    logic [COL_W-1:0] col_q;
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] tot_q;
    logic             bst_q;

    // Effective length and the clamp at the last column of the row.
    always_comb begin
        len_eff = (req_len == '0) ? CNT_W'(1) : req_len;
        room    = CNT_W'(NCOL) - CNT_W'(start_col);
        words_w = (len_eff > room) ? room : len_eff;
        burst_w = (len_eff > CNT_W'(1));
    end

    // Track the next column to issue and the words still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            rem_q <= '0;
            tot_q <= '0;
            bst_q <= 1'b0;
        end else if (load) begin
            col_q <= first_issue ? start_col + 1'b1 : start_col;
            rem_q <= first_issue ? words_w - 1'b1 : words_w;
            tot_q <= words_w;
            bst_q <= burst_w;
        end else if (adv) begin
            col_q <= col_q + 1'b1;
            rem_q <= rem_q - 1'b1;
        end
    end

    assign cur_col = col_q;
    assign rem_cnt = rem_q;
    assign total   = tot_q;
    assign burst_r = bst_q;

    // R6: a column is only issued while words remain to be fetched.
    a_r6_adv_has_words: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (rem_q != '0));
endmodule

// File: rtl/pgd_ret_pipe.sv
// Return tracker that aligns the column-strobe issue with the data coming back.
// Assumes: the array presents data exactly LAT cycles after the strobe.
module pgd_ret_pipe #(
    parameter int LAT   = 2,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [CNT_W-1:0] in_cnt,
    output logic             out_valid,
    output logic             out_last,
    output logic [CNT_W-1:0] out_cnt
);
    logic             v_q [LAT];
    logic             l_q [LAT];
    logic [CNT_W-1:0] c_q [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            // First stage captures the strobe just issued.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[0] <= 1'b0;
                    l_q[0] <= 1'b0;
                    c_q[0] <= '0;
                end else begin
                    v_q[0] <= in_valid;
                    l_q[0] <= in_last;
                    c_q[0] <= in_cnt;
                end
            end
        end else begin : g_tail
            // Later stages shift the tag toward the data return.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[s] <= 1'b0;
                    l_q[s] <= 1'b0;
                    c_q[s] <= '0;
                end else begin
                    v_q[s] <= v_q[s-1];
                    l_q[s] <= l_q[s-1];
                    c_q[s] <= c_q[s-1];
                end
            end
        end
    end

    assign out_valid = v_q[LAT-1];
    assign out_last  = v_q[LAT-1] & l_q[LAT-1];
    assign out_cnt   = c_q[LAT-1];

    // R7: a completion always reports at least one word.
    a_r7_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_cnt != '0));
endmodule

// File: rtl/pgdram_seq.sv
// Open-row DRAM read sequencer.
// Keeps the activated row open and serves same-row requests with column
// strobes only. Closes the row with a precharge on a row change or at the
// end of a burst. Assumes T_RP, T_RCD and T_CL are all at least 1 and that
// the array returns data T_CL cycles after each column strobe.
module pgdram_seq
    import pgd_pkg::*;
#(
    parameter int ROW_W  = 6,
    parameter int COL_W  = 5,
    parameter int DATA_W = 16,
    parameter int T_RP   = 2,
    parameter int T_RCD  = 3,
    parameter int T_CL   = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic [ROW_W-1:0]                       req_row,
    input  logic [COL_W-1:0]                       req_col,
    input  logic [COL_W:0]                         req_len,
    output logic                                   dr_ras,
    output logic                                   dr_cas,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dr_addr,
    input  logic [DATA_W-1:0]                      dr_rdata,
    output logic                                   rd_valid,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   done_valid,
    output logic [COL_W:0]                         done_words
);
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int CNT_W  = COL_W + 1;
    localparam int TMAX   = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int TW     = $clog2(TMAX + 1);

    pgd_state_e        state_q, nxt;
    logic              ras_q, ras_nxt;
    logic              cas_q;
    logic              cas_last_q;
    logic [CNT_W-1:0]  cas_cnt_q;
    logic [ADDR_W-1:0] addr_q, addr_nxt;
    logic [ROW_W-1:0]  row_q, row_nxt;
    logic              pend_q, pend_nxt;

    logic              accept, row_hit;
    logic              tm_load, tm_done;
    logic [TW-1:0]     tm_val;
    logic              bg_load, bg_first, bg_adv;
    logic [CNT_W-1:0]  bg_words, bg_rem, bg_total;
    logic              bg_burst_w, bg_burst_r;
    logic [COL_W-1:0]  bg_col;
    logic              issue, iss_last;
    logic [COL_W-1:0]  iss_col;
    logic [CNT_W-1:0]  iss_cnt;

    assign req_ready = (state_q == PS_IDLE) || (state_q == PS_OPEN);
    assign accept    = req_valid && req_ready;
    assign row_hit   = (req_row == row_q);

    pgd_delay #(.TW(TW)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tm_load),
        .val  (tm_val),
        .done (tm_done)
    );

    pgd_burst_gen #(.COL_W(COL_W), .CNT_W(CNT_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (bg_load),
        .first_issue(bg_first),
        .adv        (bg_adv),
        .start_col  (req_col),
        .req_len    (req_len),
        .words_w    (bg_words),
        .burst_w    (bg_burst_w),
        .cur_col    (bg_col),
        .rem_cnt    (bg_rem),
        .total      (bg_total),
        .burst_r    (bg_burst_r)
    );

    // Next state, strobe levels and column issue for this cycle.
    always_comb begin
        nxt      = state_q;
        ras_nxt  = ras_q;
        addr_nxt = addr_q;
        row_nxt  = row_q;
        pend_nxt = pend_q;
        tm_load  = 1'b0;
        tm_val   = '0;
        bg_load  = 1'b0;
        bg_first = 1'b0;
        bg_adv   = 1'b0;
        issue    = 1'b0;
        iss_col  = '0;
        iss_last = 1'b0;
        iss_cnt  = '0;
        case (state_q)
            PS_IDLE: if (accept) begin
                bg_load  = 1'b1;
                ras_nxt  = 1'b1;
                addr_nxt = ADDR_W'(req_row);
                row_nxt  = req_row;
                tm_load  = 1'b1;
                tm_val   = TW'(T_RCD - 1);
                nxt      = PS_ACT;
            end
            PS_OPEN: if (accept) begin
                bg_load = 1'b1;
                if (row_hit) begin
                    bg_first = 1'b1;
                    issue    = 1'b1;
                    iss_col  = req_col;
                    iss_last = (bg_words == CNT_W'(1));
                    iss_cnt  = bg_words;
                    if (bg_words == CNT_W'(1))
                        nxt = bg_burst_w ? PS_CLOSE : PS_OPEN;
                    else
                        nxt = PS_BURST;
                end else begin
                    ras_nxt  = 1'b0;
                    row_nxt  = req_row;
                    pend_nxt = 1'b1;
                    tm_load  = 1'b1;
                    tm_val   = TW'(T_RP - 1);
                    nxt      = PS_PRE;
                end
            end
            PS_PRE: if (tm_done) begin
                if (pend_q) begin
                    ras_nxt  = 1'b1;
                    addr_nxt = ADDR_W'(row_q);
                    pend_nxt = 1'b0;
                    tm_load  = 1'b1;
                    tm_val   = TW'(T_RCD - 1);
                    nxt      = PS_ACT;
                end else begin
                    nxt = PS_IDLE;
                end
            end
            PS_ACT, PS_BURST: if (state_q == PS_BURST || tm_done) begin
                issue    = 1'b1;
                bg_adv   = 1'b1;
                iss_col  = bg_col;
                iss_last = (bg_rem == CNT_W'(1));
                iss_cnt  = bg_total;
                if (bg_rem == CNT_W'(1))
                    nxt = bg_burst_r ? PS_CLOSE : PS_OPEN;
                else
                    nxt = PS_BURST;
            end
            PS_CLOSE: begin
                ras_nxt = 1'b0;
                tm_load = 1'b1;
                tm_val  = TW'(T_RP - 1);
                nxt     = PS_PRE;
            end
            default: nxt = PS_IDLE;
        endcase
        if (issue) addr_nxt = ADDR_W'(iss_col);
    end

    // Register the state, the strobes and the address bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PS_IDLE;
            ras_q      <= 1'b0;
            cas_q      <= 1'b0;
            cas_last_q <= 1'b0;
            cas_cnt_q  <= '0;
            addr_q     <= '0;
            row_q      <= '0;
            pend_q     <= 1'b0;
        end else begin
            state_q    <= nxt;
            ras_q      <= ras_nxt;
            cas_q      <= issue;
            cas_last_q <= iss_last;
            cas_cnt_q  <= iss_cnt;
            addr_q     <= addr_nxt;
            row_q      <= row_nxt;
            pend_q     <= pend_nxt;
        end
    end

    pgd_ret_pipe #(.LAT(T_CL), .CNT_W(CNT_W)) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (cas_q),
        .in_last  (cas_last_q),
        .in_cnt   (cas_cnt_q),
        .out_valid(rd_valid),
        .out_last (done_valid),
        .out_cnt  (done_words)
    );

    assign dr_ras  = ras_q;
    assign dr_cas  = cas_q;
    assign dr_addr = addr_q;
    assign rd_data = dr_rdata;

    // R4: column strobes only inside an open row.
    a_r4_cas_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
        cas_q |-> ras_q);

    // R2: the cycle that opens a row carries the row, not a column.
    a_r2_row_before_col: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_q) |-> !cas_q);

    // R3: a same-row hit yields a column strobe with the row left open.
    a_r3_hit_cas_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OPEN && accept && row_hit) |=> (cas_q && ras_q && $stable(ras_q)));

    // R5: a row change starts with the row strobe dropping.
    a_r5_miss_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OPEN && accept && !row_hit) |=> (!ras_q && !req_ready));

    // R6: inside a burst each column is one above the last.
    a_r6_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_q && $past(state_q) == PS_BURST) |->
            (addr_q[COL_W-1:0] == COL_W'($past(addr_q[COL_W-1:0]) + 1'b1)));

    // R7: a burst never wraps past the last column back to zero.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_q && $past(state_q) == PS_BURST) |-> (addr_q[COL_W-1:0] != '0));
endmodule

// File: tb/pgdram_seq_bench.sv
module pgdram_seq_bench;
    localparam int RW   = 6;
    localparam int CW   = 5;
    localparam int DW   = 16;
    localparam int TRP  = 2;
    localparam int TRCD = 3;
    localparam int TCL  = 2;
    localparam int AW   = (RW > CW) ? RW : CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [CW:0]   req_len = '0;
    logic          dr_ras, dr_cas;
    logic [AW-1:0] dr_addr;
    logic [DW-1:0] dr_rdata;
    logic          rd_valid, done_valid;
    logic [DW-1:0] rd_data;
    logic [CW:0]   done_words;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int cap_n = 0, done_n = 0, ras_rises = 0, bad_cas = 0;
    int cap_cyc [64];
    logic [DW-1:0] cap_dat [64];
    int last_done_cnt = 0;
    logic ras_seen = 1'b0;

    always #2.5 clk = ~clk;

    pgdram_seq #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .T_RP(TRP), .T_RCD(TRCD), .T_CL(TCL)) u_pgdram_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .dr_ras(dr_ras), .dr_cas(dr_cas), .dr_addr(dr_addr), .dr_rdata(dr_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .done_valid(done_valid), .done_words(done_words)
    );

    function automatic logic [DW-1:0] pat(input int row, input int col);
        return {5'h15, RW'(row), CW'(col)};
    endfunction

    // Behavioural array: latches the row on the strobe rise, returns data TCL cycles after a column strobe.
    logic [RW-1:0] m_row;
    logic          m_ras_d;
    logic [DW-1:0] m_pipe [TCL];
    always @(posedge clk) begin
        if (!rst_n) m_ras_d <= 1'b0;
        else m_ras_d <= dr_ras;
        if (dr_ras && !m_ras_d) m_row <= dr_addr[RW-1:0];
        m_pipe[0] <= dr_cas ? pat(int'(m_row), int'(dr_addr[CW-1:0])) : '0;
        for (int i = 1; i < TCL; i++) m_pipe[i] <= m_pipe[i-1];
    end
    assign dr_rdata = m_pipe[TCL-1];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: stamp returned words and completions, count row openings.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid && cap_n < 64) begin
                cap_cyc[cap_n] = cyc;
                cap_dat[cap_n] = rd_data;
                cap_n = cap_n + 1;
            end
            if (done_valid) begin
                done_n = done_n + 1;
                last_done_cnt = int'(done_words);
            end
            if (dr_ras && !ras_seen) ras_rises = ras_rises + 1;
            if (dr_cas && !dr_ras) bad_cas = bad_cas + 1;
            ras_seen = dr_ras;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int row, input int col, input int len, output int acc);
        @(negedge clk);
        req_valid = 1'b1;
        req_row = RW'(row);
        req_col = CW'(col);
        req_len = (CW+1)'(len);
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_words(input int n0, input int k);
        for (int i = 0; i < 100 && cap_n < n0 + k; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ras", int'(dr_ras), 0);
        check("R1 cas", int'(dr_cas), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 done_valid", int'(done_valid), 0);
        check("R1 ready", int'(req_ready), 1);
    endtask

    task automatic t_first_open;
        int n0 = cap_n, r0 = ras_rises, acc;
        send(5, 3, 1, acc);
        wait_words(n0, 1);
        check("R2 latency", cap_cyc[n0] - acc, TRCD + TCL);
        check("R2 data", int'(cap_dat[n0]), int'(pat(5, 3)));
        check("R2 row opened", ras_rises - r0, 1);
        check("R9 single count", last_done_cnt, 1);
    endtask

    task automatic t_hit;
        int n0 = cap_n, r0 = ras_rises, acc;
        send(5, 10, 1, acc);
        wait_words(n0, 1);
        check("R3 hit latency", cap_cyc[n0] - acc, TCL);
        check("R3 hit data", int'(cap_dat[n0]), int'(pat(5, 10)));
        check("R3 no new row", ras_rises - r0, 0);
    endtask

    task automatic t_back_to_back;
        int n0 = cap_n, r0 = ras_rises, acc = 0, ok_rdy = 1, ok_ras = 1;
        int cols [4] = '{0, 1, 31, 7};
        @(negedge clk);
        req_valid = 1'b1;
        req_row = RW'(5);
        req_len = '0 + 1;
        for (int i = 0; i < 4; i++) begin
            req_col = CW'(cols[i]);
            if (!req_ready) ok_rdy = 0;
            if (!dr_ras) ok_ras = 0;
            if (i == 0) acc = cyc + 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_words(n0, 4);
        check("R3 ready every cycle", ok_rdy, 1);
        check("R4 ras held during hits", ok_ras, 1);
        for (int i = 0; i < 4; i++) begin
            check("R3 b2b timing", cap_cyc[n0+i] - acc, TCL + i);
            check("R3 b2b data", int'(cap_dat[n0+i]), int'(pat(5, cols[i])));
        end
        check("R3 b2b no new row", ras_rises - r0, 0);
    endtask

    task automatic t_len_zero;
        int n0 = cap_n, d0 = done_n, acc;
        send(5, 4, 0, acc);
        wait_words(n0, 1);
        repeat (3) @(negedge clk);
        check("R9 one word", cap_n - n0, 1);
        check("R9 count", last_done_cnt, 1);
        check("R9 one completion", done_n - d0, 1);
        check("R9 row left open", int'(dr_ras), 1);
    endtask

    task automatic t_miss;
        int n0 = cap_n, r0 = ras_rises, acc;
        send(9, 2, 1, acc);
        check("R5 ready low in precharge", int'(req_ready), 0);
        check("R5 ras low in precharge", int'(dr_ras), 0);
        wait_words(n0, 1);
        check("R5 miss latency", cap_cyc[n0] - acc, TRP + TRCD + TCL);
        check("R5 new row data", int'(cap_dat[n0]), int'(pat(9, 2)));
        check("R5 row reopened", ras_rises - r0, 1);
    endtask

    task automatic t_burst;
        int n0 = cap_n, acc;
        send(9, 8, 4, acc);
        wait_words(n0, 4);
        check("R6 burst latency", cap_cyc[n0] - acc, TCL);
        for (int i = 0; i < 4; i++) begin
            check("R6 burst timing", cap_cyc[n0+i] - cap_cyc[n0], i);
            check("R6 burst data", int'(cap_dat[n0+i]), int'(pat(9, 8 + i)));
        end
        check("R7 burst count", last_done_cnt, 4);
        check("R8 row closed after burst", int'(dr_ras), 0);
        n0 = cap_n;
        send(9, 0, 1, acc);
        wait_words(n0, 1);
        check("R8 reopen latency", cap_cyc[n0] - acc, TRCD + TCL);
        check("R8 reopen data", int'(cap_dat[n0]), int'(pat(9, 0)));
    endtask

    task automatic t_clamp;
        int n0 = cap_n, d0 = done_n, acc;
        send(9, 29, 8, acc);
        wait_words(n0, 3);
        repeat (5) @(negedge clk);
        check("R7 clamped words", cap_n - n0, 3);
        check("R7 clamped count", last_done_cnt, 3);
        check("R7 one completion", done_n - d0, 1);
        for (int i = 0; i < 3; i++)
            check("R7 clamped data", int'(cap_dat[n0+i]), int'(pat(9, 29 + i)));
    endtask

    task automatic t_pending_at_close;
        int n0 = cap_n, r0 = ras_rises, acc0, acc1;
        send(12, 0, 2, acc0);
        send(12, 5, 1, acc1);
        wait_words(n0, 3);
        check("R6 short burst data", int'(cap_dat[n0+1]), int'(pat(12, 1)));
        check("R8 pending same row latency", cap_cyc[n0+2] - acc1, TRCD + TCL);
        check("R8 pending same row data", int'(cap_dat[n0+2]), int'(pat(12, 5)));
        check("R8 row opened twice", ras_rises - r0, 2);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_open();
        t_hit();
        t_back_to_back();
        t_len_zero();
        t_miss();
        t_burst();
        t_clamp();
        t_pending_at_close();
        check("R4 no column strobe outside a row", bad_cas, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule